// File: doc/BRIEF.md
# Reset Sequencer with Switchable Clock Output

This block turns two reset sources into one clean internal reset for a converter data path. A low level on the asynchronous external reset pin, or a low power-good level, clears a two-stage synchronizer at once. When both sources are released, the synchronizer lets go on a clock edge. A counter then keeps the internal reset asserted for a fixed number of system clocks. During this time, and until the control registers have been reloaded, the data path is told to output the mid-scale (bipolar-zero) code. The register reload is a single-cycle strobe. It is issued on the first sample-period strobe that arrives after the count has finished, so the new settings begin on a frame boundary.

The block also drives a buffered copy of the system clock. Two control bits pick full rate or half rate and turn the output on or off. The full-rate path gates the clock with an enable that is sampled on the falling edge. The half-rate path uses a toggle flop that is held low while disabled. For as long as the internal reset is active, the output ignores the control bits and runs enabled at full rate, which are the register defaults.

Top module: `init_sequencer`

## Requirements
- R1: While `ext_rst_n` is low or `pwr_ok` is low, `int_rst` and `force_zero` are 1 and `reg_load` is 0, without waiting for a clock edge.
- R2: After both reset sources go high between clock edges, `int_rst` stays 1 through rising edge SYNC_STAGES+INIT_CYCLES-1 and is 0 after rising edge SYNC_STAGES+INIT_CYCLES (2+1024 with default parameters).
- R3: A low pulse on `ext_rst_n` shorter than one clock period that arrives during the count restarts the count, and the R2 latency is measured from the end of that pulse.
- R4: `force_zero` is 1 whenever `int_rst` is 1. It stays 1 after `int_rst` falls, until the cycle in which `reg_load` is 1.
- R5: `frame_tick` pulses seen while `int_rst` is 1 have no effect. The first `frame_tick` sampled high on a rising edge after `int_rst` has fallen makes `reg_load` 1 for exactly the next clock cycle, and `force_zero` falls in that same cycle.
- R6: After `reg_load` has pulsed, further `frame_tick` pulses give no `reg_load` pulse until the next reset.
- R7: With `clkout_en`=1 and `clkout_half`=0, `clk_out` is 1 while `clk` is high and 0 while `clk` is low.
- R8: With `clkout_en`=1 and `clkout_half`=1, `clk_out` changes level only just after rising edges of `clk`, and it inverts on every rising edge (half the clock rate).
- R9: With `clkout_en`=0, `clk_out` stays at 0 in both rate settings.
- R10: While `int_rst` is 1, `clk_out` follows `clk` at full rate, whatever `clkout_en` and `clkout_half` are.
- R11: Changes to `clkout_en` or `clkout_half` take effect within three clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | Asynchronous external reset, active low |
| pwr_ok | input | 1 | Power-good level, low requests reset |
| frame_tick | input | 1 | One-cycle strobe at each sample period |
| clkout_half | input | 1 | 1 selects half-rate clock output, 0 full rate |
| clkout_en | input | 1 | 1 enables the clock output |
| int_rst | output | 1 | Internal reset, high during sync and count |
| force_zero | output | 1 | Forces mid-scale data path output |
| reg_load | output | 1 | One-cycle register default load strobe |
| clk_out | output | 1 | Buffered clock output |

## Verification
The assertions check the ordering rules on every cycle: `force_zero` covers `int_rst`, `reg_load` lasts one cycle, never appears during reset, and is the only way `force_zero` falls. Only the bench scenarios can show the exact count latency measured from release, that a sub-cycle reset glitch restarts the count, that frame strobes are ignored before and after the load window, and the waveform of the clock output in each mode, including the forced default during reset.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

   typedef enum logic [1:0] {
      PH_COUNT = 2'd0,
      PH_WAIT  = 2'd1,
      PH_RUN   = 2'd2
   } init_phase_e;

endpackage

// File: rtl/init_rst_sync.sv
module init_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);

   if (STAGES < 2) begin : g_bad_stages
      $error("init_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[0] <= 1'b0;
            else         chain[0] <= 1'b1;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[s] <= 1'b0;
            else         chain[s] <= chain[s-1];
         end
      end
   end

   assign rst_n = chain[STAGES-1];

endmodule

// File: rtl/init_phase_fsm.sv
module init_phase_fsm
   import init_seq_pkg::*;
#(
   parameter int INIT_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_tick,
   output logic int_rst,
   output logic force_zero,
   output logic reg_load
);

   localparam int CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

   if (INIT_CYCLES < 2) begin : g_bad_cycles
      $error("init_phase_fsm: INIT_CYCLES must be at least 2");
   end

   init_phase_e   phase;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_COUNT;
         cnt      <= '0;
         reg_load <= 1'b0;
      end else begin
         reg_load <= 1'b0;
         unique case (phase)
            PH_COUNT: begin
               if (cnt == LAST) begin
                  phase <= PH_WAIT;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_WAIT: begin
               if (frame_tick) begin
                  phase    <= PH_RUN;
                  reg_load <= 1'b1;
               end
            end
            default: phase <= PH_RUN;
         endcase
      end
   end

   assign int_rst    = (phase == PH_COUNT);
   assign force_zero = (phase != PH_RUN);

endmodule

// File: rtl/init_clkout.sv
module init_clkout #(
   parameter bit HAS_HALF = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_dflt,
   input  logic half_req,
   input  logic en_req,
   output logic clk_out
);

   logic en_eff;
   logic en_q;

   assign en_eff = force_dflt | en_req;

   // enable only moves while clk is low, so the AND gate cannot chop a pulse
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b1;
      else        en_q <= en_eff;
   end

   if (HAS_HALF) begin : g_half
      logic half_eff;
      logic half_q;
      logic tog;

      assign half_eff = ~force_dflt & half_req;

      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) half_q <= 1'b0;
         else        half_q <= half_eff;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      tog <= 1'b0;
         else if (en_eff) tog <= ~tog;
         else             tog <= 1'b0;
      end

      assign clk_out = half_q ? tog : (clk & en_q);
   end else begin : g_full_only
      logic unused_half;
      assign unused_half = half_req;
      assign clk_out = clk & en_q;
   end

endmodule

// File: rtl/init_sequencer.sv
module init_sequencer #(
   parameter int INIT_CYCLES = 1024,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_HALF    = 1'b1
) (
   input  logic clk,
   input  logic ext_rst_n,
   input  logic pwr_ok,
   input  logic frame_tick,
   input  logic clkout_half,
   input  logic clkout_en,
   output logic int_rst,
   output logic force_zero,
   output logic reg_load,
   output logic clk_out
);

   logic src_rst_n;
   logic sync_rst_n;

   assign src_rst_n = ext_rst_n & pwr_ok;

   init_rst_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .arst_n (src_rst_n),
      .rst_n  (sync_rst_n)
   );

   init_phase_fsm #(
      .INIT_CYCLES (INIT_CYCLES)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (sync_rst_n),
      .frame_tick (frame_tick),
      .int_rst    (int_rst),
      .force_zero (force_zero),
      .reg_load   (reg_load)
   );

   init_clkout #(
      .HAS_HALF (HAS_HALF)
   ) u_clkout (
      .clk        (clk),
      .rst_n      (sync_rst_n),
      .force_dflt (int_rst),
      .half_req   (clkout_half),
      .en_req     (clkout_en),
      .clk_out    (clk_out)
   );

endmodule

// File: rtl/init_sequencer_chk.sv
module init_sequencer_chk (
   input logic clk,
   input logic ext_rst_n,
   input logic pwr_ok,
   input logic frame_tick,
   input logic clkout_half,
   input logic clkout_en,
   input logic int_rst,
   input logic force_zero,
   input logic reg_load,
   input logic clk_out
);

   // R4
   zero_cover_chk: assert property (@(posedge clk) disable iff (!ext_rst_n || !pwr_ok)
      int_rst |-> force_zero);

   // R5
   load_single_chk: assert property (@(posedge clk) disable iff (!ext_rst_n || !pwr_ok)
      reg_load |=> !reg_load);

   // R5
   load_not_in_rst_chk: assert property (@(posedge clk) disable iff (!ext_rst_n || !pwr_ok)
      int_rst |-> !reg_load);

   // R4
   zero_release_chk: assert property (@(posedge clk) disable iff (!ext_rst_n || !pwr_ok)
      $fell(force_zero) |-> reg_load);

endmodule

bind init_sequencer init_sequencer_chk u_chk (.*);

// File: tb/init_sequencer_bench.sv
module init_sequencer_bench;

   localparam int INIT = 1024;
   localparam int SYNC = 2;
   localparam int LAT  = INIT + SYNC;

   logic clk = 1'b0;
   logic ext_rst_n, pwr_ok, frame_tick, clkout_half, clkout_en;
   logic int_rst, force_zero, reg_load, clk_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   init_sequencer #(
      .INIT_CYCLES (INIT),
      .SYNC_STAGES (SYNC),
      .HAS_HALF    (1'b1)
   ) u_init_sequencer (
      .clk         (clk),
      .ext_rst_n   (ext_rst_n),
      .pwr_ok      (pwr_ok),
      .frame_tick  (frame_tick),
      .clkout_half (clkout_half),
      .clkout_en   (clkout_en),
      .int_rst     (int_rst),
      .force_zero  (force_zero),
      .reg_load    (reg_load),
      .clk_out     (clk_out)
   );

   task automatic check(input logic act, input logic exp, input string tag);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // caller has just released reset between edges
   task automatic count_check(input string tag);
      for (int i = 1; i <= LAT; i++) begin
         @(posedge clk); #1;
         check(int_rst, (i < LAT) ? 1'b1 : 1'b0, tag);
         check(reg_load, 1'b0, "R5 no load during count");
         frame_tick = (i % 97 == 3) ? 1'b1 : 1'b0; // ignored ticks (R5)
      end
      frame_tick = 1'b0;
   endtask

   task automatic load_check();
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); #1;
         check(force_zero, 1'b1, "R4 zero held until load");
         check(reg_load, 1'b0, "R5 no load before tick");
      end
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0; #1;
      check(reg_load, 1'b1, "R5 load after tick");
      check(force_zero, 1'b0, "R5 zero falls with load");
      @(negedge clk); #1;
      check(reg_load, 1'b0, "R5 load one cycle");
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); frame_tick = 1'b1;
         @(negedge clk); frame_tick = 1'b0; #1;
         check(reg_load, 1'b0, "R6 no second load");
         check(force_zero, 1'b0, "R6 zero stays off");
      end
   endtask

   task automatic full_check(input string tag);
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1; check(clk_out, 1'b1, tag);
         @(negedge clk); #1; check(clk_out, 1'b0, tag);
      end
   endtask

   task automatic off_check(input string tag);
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1; check(clk_out, 1'b0, tag);
         @(negedge clk); #1; check(clk_out, 1'b0, tag);
      end
   endtask

   task automatic half_check();
      logic prev;
      @(posedge clk); #1; prev = clk_out;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk); #1; check(clk_out, prev, "R8 hold through low phase");
         @(posedge clk); #1; check(clk_out, ~prev, "R8 invert each edge");
         prev = clk_out;
      end
   endtask

   task automatic set_ctrl(input logic en, input logic half);
      @(posedge clk); #2;
      clkout_en = en; clkout_half = half;
      repeat (3) @(posedge clk); // R11 settle window
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      ext_rst_n = 1'b0; pwr_ok = 1'b1; frame_tick = 1'b0;
      clkout_en = 1'b0; clkout_half = 1'b1;
      repeat (5) @(negedge clk);
      #1;
      check(int_rst, 1'b1, "R1 reset state int_rst");
      check(force_zero, 1'b1, "R1 reset state force_zero");
      check(reg_load, 1'b0, "R1 reset state reg_load");
      full_check("R10 default clock during reset");

      // first release, count with ignored ticks, controls disregarded (R10)
      @(negedge clk); ext_rst_n = 1'b1;
      count_check("R2 count latency");
      load_check();

      // R7 R9 R8 R11 sweep of control bits in run state
      set_ctrl(1'b1, 1'b0); full_check("R7 full rate");
      set_ctrl(1'b0, 1'b0); off_check("R9 disabled full");
      set_ctrl(1'b1, 1'b1); half_check();
      set_ctrl(1'b0, 1'b1); off_check("R9 disabled half");
      set_ctrl(1'b1, 1'b0); full_check("R11 back to full");

      // R1 power-good drop
      @(negedge clk); #1; pwr_ok = 1'b0; #1;
      check(int_rst, 1'b1, "R1 pwr_ok low int_rst");
      check(force_zero, 1'b1, "R1 pwr_ok low force_zero");
      clkout_en = 1'b0; clkout_half = 1'b1;
      full_check("R10 forced default after power drop");
      @(negedge clk); pwr_ok = 1'b1;
      for (int i = 0; i < 500; i++) begin
         @(posedge clk); #1;
         check(int_rst, 1'b1, "R2 still counting");
      end
      // R3 narrow pulse between edges restarts the count
      @(negedge clk); ext_rst_n = 1'b0; #1;
      check(int_rst, 1'b1, "R3 glitch asserts");
      #2; ext_rst_n = 1'b1;
      count_check("R3 restart latency");
      load_check();
      set_ctrl(1'b0, 1'b1); off_check("R9 after second load");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule